// File: doc/BRIEF.md
# Serial Configuration Register and Chip-Select Router

This block sits between a host serial master and the front end of a four-channel frequency synthesizer board. The host drives a clock, a data line and a 3-bit target code. A code of zero means the bus is idle. The block decodes the code and does one of two things: it handles the transfer itself as a configuration/status access, or it passes the bus through to one downstream target. The downstream targets are the attenuator chain, any single synthesizer channel, or all four synthesizer channels at once.

A configuration access is a full-duplex 24-bit frame. As the host shifts a new control word in, the block shifts a status word out. The status word is taken at the start of the frame. The control word is applied only when the frame ends with exactly 24 clocks. The control word drives the board's static control pins directly: RF switch enables, LEDs, the profile pins shared by all channels, the I/O update line, reset lines, clock and sync source selects, and the reference divider select.

The host interface is sampled with the system clock. SCLK, MOSI and the configuration select pass through a synchroniser, and edges are found in the system-clock domain. The system clock must therefore run several times faster than SCLK. The forwarded bus lines and the target selects are combinational, so pass-through adds no latency.

Top module: `spi_cfg_router`

## Requirements
- R1: After reset, every control output reads zero: led, profile, io_update, mask_nu, clk_sel, sync_sel, dds_rst, io_rst and clk_div. rf_sw equals sw_ext. No downstream select is active, and host_miso reads 0 while the code is 0.
- R2: A code-1 frame uses mode 0: SCLK idles low, data is sampled on the rising edge, and the word is sent MSB first. When the frame ends after exactly 24 rising edges, the received word is applied to the outputs. The bit positions are: rf 3:0, led 7:4, profile 10:8, bit 11 unused, io_update 12, mask_nu 16:13, clk_sel[0] 17, sync_sel 18, dds_rst 19, io_rst 20, clk_sel[1] 21, clk_div 23:22.
- R3: A code-1 frame with any other number of rising edges (for example 23 or 25) leaves every control output unchanged.
- R4: During a code-1 frame, host_miso carries a 24-bit status word, MSB first, captured when the frame starts. Its layout is: rf switch state (control bits OR sw_ext) in 3:0, smp_err in 7:4, pll_lock in 11:8, ifc_mode in 15:12, revision 0x08 in 22:16, and 0 in bit 23. Each bit is valid before the rising edge that samples it.
- R5: Code 2 raises att_sel alone. fwd_sclk and fwd_mosi follow host_sclk and host_mosi, and host_miso follows att_miso. No control output changes.
- R6: Code 3 raises all four syn_sel bits, and host_miso follows syn_miso[0].
- R7: Codes 4, 5, 6 and 7 raise only syn_sel[0], [1], [2] and [3] respectively, and host_miso follows that channel's miso line.
- R8: rf_sw[i] is the OR of control bit i and sw_ext[i], and it tracks sw_ext without a clock.
- R9: io_update follows control bit 12. Two frames, one setting the bit and one clearing it, produce a pulse.
- R10: With code 0 or code 1, fwd_sclk and fwd_mosi stay low and no downstream select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 3 | Target code, 0 idle |
| host_sclk | input | 1 | Host serial clock |
| host_mosi | input | 1 | Host serial data in |
| host_miso | output | 1 | Serial data back to host |
| att_sel | output | 1 | Attenuator chain select, active high |
| syn_sel | output | 4 | Synthesizer channel selects, active high |
| fwd_sclk | output | 1 | Forwarded serial clock |
| fwd_mosi | output | 1 | Forwarded serial data |
| att_miso | input | 1 | Attenuator chain return data |
| syn_miso | input | 4 | Synthesizer return data per channel |
| sw_ext | input | 4 | External RF switch lines |
| smp_err | input | 4 | Sample-error flags |
| pll_lock | input | 4 | PLL lock flags |
| ifc_mode | input | 4 | Interface mode straps |
| rf_sw | output | 4 | RF switch enables |
| led | output | 4 | LED drives |
| profile | output | 3 | Profile pins shared by all channels |
| io_update | output | 1 | I/O update line |
| mask_nu | output | 4 | Channel mask bits |
| clk_sel | output | 2 | Reference clock source select |
| sync_sel | output | 1 | Sync source select |
| dds_rst | output | 1 | Synthesizer master reset |
| io_rst | output | 1 | Synthesizer I/O reset |
| clk_div | output | 2 | Reference divider select |

## Verification
The bench uses the default parameters: two synchroniser stages and revision 0x08. SCLK is run at one sixteenth of the system clock, which leaves several clock cycles between each SCLK edge and the point where the synchronised edge is detected. Random control words and random status inputs exercise every field position in both directions. Directed frames of 23 and 25 clocks probe the exact-length rule, and every target code from 0 to 7 is driven to check selects, pass-through and the return-data multiplexer.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int CH_COUNT   = 4;
    localparam int CODE_W     = 3;
    localparam int FRAME_BITS = 24;
    localparam int REV_W      = 7;

    localparam logic [CODE_W-1:0] CODE_IDLE  = 3'd0;
    localparam logic [CODE_W-1:0] CODE_CFG   = 3'd1;
    localparam logic [CODE_W-1:0] CODE_ATT   = 3'd2;
    localparam logic [CODE_W-1:0] CODE_BCAST = 3'd3;
    localparam logic [CODE_W-1:0] CODE_CH0   = 3'd4;

    // control word, MSB first (bit 23 down to bit 0)
    typedef struct packed {
        logic [1:0]          clk_div;   // 23:22
        logic                clk_sel1;  // 21
        logic                io_rst;    // 20
        logic                dds_rst;   // 19
        logic                sync_sel;  // 18
        logic                clk_sel0;  // 17
        logic [CH_COUNT-1:0] mask_nu;   // 16:13
        logic                io_upd;    // 12
        logic                rsvd;      // 11
        logic [2:0]          profile;   // 10:8
        logic [CH_COUNT-1:0] led;       // 7:4
        logic [CH_COUNT-1:0] rf;        // 3:0
    } ctrl_t;

    // status word, MSB first
    typedef struct packed {
        logic                zero;      // 23
        logic [REV_W-1:0]    rev;       // 22:16
        logic [CH_COUNT-1:0] ifc;       // 15:12
        logic [CH_COUNT-1:0] lock;      // 11:8
        logic [CH_COUNT-1:0] smp;       // 7:4
        logic [CH_COUNT-1:0] rf;        // 3:0
    } stat_t;

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter
    import spi_cfg_pkg::*;
#(
    parameter int BITS = FRAME_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_s,     // synchronised config select
    input  logic            sclk_s,
    input  logic            mosi_s,
    input  logic [BITS-1:0] status_i,
    output logic            miso_o,
    output logic            commit_o,
    output logic [BITS-1:0] word_o
);
    localparam int CNT_W   = $clog2(BITS + 2);
    localparam int CNT_SAT = BITS + 1;

    typedef struct packed {
        logic             sclk_prev;
        logic             sel_prev;
        logic [CNT_W-1:0] cnt;
        logic [BITS-1:0]  rx;
        logic [BITS-1:0]  tx;
        logic             commit;
        logic [BITS-1:0]  word;
    } sh_t;

    sh_t st_d, st_q;
    logic start, finish, rise, fall;

    assign start  = sel_s && !st_q.sel_prev;
    assign finish = !sel_s && st_q.sel_prev;
    assign rise   = sclk_s && !st_q.sclk_prev;
    assign fall   = !sclk_s && st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.sel_prev  = sel_s;
        st_d.commit    = 1'b0;
        if (start) begin
            st_d.tx  = status_i;
            st_d.rx  = '0;
            st_d.cnt = '0;
        end else if (sel_s) begin
            if (rise) begin
                st_d.rx = {st_q.rx[BITS-2:0], mosi_s};
                if (st_q.cnt != CNT_W'(CNT_SAT)) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (fall) st_d.tx = {st_q.tx[BITS-2:0], 1'b0};
        end
        if (finish && st_q.cnt == CNT_W'(BITS)) begin
            st_d.commit = 1'b1;
            st_d.word   = st_q.rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso_o   = st_q.tx[BITS-1];
    assign commit_o = st_q.commit;
    assign word_o   = st_q.word;

    // R2: a capture only follows a frame of the exact length
    a_r2_exact_len: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(st_q.cnt) == CNT_W'(BITS));

    // R4: the status word is loaded at the start of the frame
    a_r4_status_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> st_q.tx == $past(status_i));

    // R3: bit counter never passes its saturation value
    a_r3_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(CNT_SAT));
endmodule

// File: rtl/spi_cfg_route.sv
module spi_cfg_route
    import spi_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   code,
    input  logic                sclk,
    input  logic                mosi,
    input  logic                cfg_miso,
    input  logic                att_miso,
    input  logic [CH_COUNT-1:0] syn_miso,
    output logic                cfg_sel,
    output logic                att_sel,
    output logic [CH_COUNT-1:0] syn_sel,
    output logic                fwd_sclk,
    output logic                fwd_mosi,
    output logic                miso
);
    logic fwd_any;
    logic [CH_COUNT-1:0] ch_hit;

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
        assign ch_hit[c]  = (code == CODE_CH0 + CODE_W'(c));
        assign syn_sel[c] = ch_hit[c] || (code == CODE_BCAST);
    end

    assign cfg_sel  = (code == CODE_CFG);
    assign att_sel  = (code == CODE_ATT);
    assign fwd_any  = att_sel || (|syn_sel);
    assign fwd_sclk = sclk && fwd_any;
    assign fwd_mosi = mosi && fwd_any;

    always_comb begin
        miso = 1'b0;
        if (cfg_sel)                  miso = cfg_miso;
        else if (att_sel)             miso = att_miso;
        else if (code == CODE_BCAST)  miso = syn_miso[0];
        else begin
            for (int c = 0; c < CH_COUNT; c++) begin
                if (ch_hit[c]) miso = syn_miso[c];
            end
        end
    end

    // R7: outside broadcast at most one downstream select
    a_r7_single_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (code != CODE_BCAST) |-> $onehot0({att_sel, syn_sel}));

    // R6: broadcast raises every channel, return data from channel 0
    a_r6_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        (code == CODE_BCAST) |-> (&syn_sel) && (miso == syn_miso[0]));

    // R10: no forwarding while idle or in a configuration access
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (code == CODE_IDLE || code == CODE_CFG) |-> !fwd_sclk && !fwd_mosi && !att_sel && syn_sel == '0);
endmodule

// File: rtl/spi_cfg_router.sv
module spi_cfg_router
    import spi_cfg_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [REV_W-1:0] PROTO_REV  = 7'h08
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   host_cs,
    input  logic                host_sclk,
    input  logic                host_mosi,
    output logic                host_miso,
    output logic                att_sel,
    output logic [CH_COUNT-1:0] syn_sel,
    output logic                fwd_sclk,
    output logic                fwd_mosi,
    input  logic                att_miso,
    input  logic [CH_COUNT-1:0] syn_miso,
    input  logic [CH_COUNT-1:0] sw_ext,
    input  logic [CH_COUNT-1:0] smp_err,
    input  logic [CH_COUNT-1:0] pll_lock,
    input  logic [CH_COUNT-1:0] ifc_mode,
    output logic [CH_COUNT-1:0] rf_sw,
    output logic [CH_COUNT-1:0] led,
    output logic [2:0]          profile,
    output logic                io_update,
    output logic [CH_COUNT-1:0] mask_nu,
    output logic [1:0]          clk_sel,
    output logic                sync_sel,
    output logic                dds_rst,
    output logic                io_rst,
    output logic [1:0]          clk_div
);
    localparam int STAT_IN_W = 4 * CH_COUNT;

    logic                  cfg_sel, cfg_miso, sel_s, sclk_s, mosi_s, commit;
    logic [FRAME_BITS-1:0] word;
    logic [STAT_IN_W-1:0]  stat_raw, stat_s;
    stat_t                 status;
    ctrl_t                 ctrl_d, ctrl_q;

    spi_cfg_route u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (host_cs),
        .sclk     (host_sclk),
        .mosi     (host_mosi),
        .cfg_miso (cfg_miso),
        .att_miso (att_miso),
        .syn_miso (syn_miso),
        .cfg_sel  (cfg_sel),
        .att_sel  (att_sel),
        .syn_sel  (syn_sel),
        .fwd_sclk (fwd_sclk),
        .fwd_mosi (fwd_mosi),
        .miso     (host_miso)
    );

    spi_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cfg_sel, host_sclk, host_mosi}),
        .dout  ({sel_s, sclk_s, mosi_s})
    );

    assign stat_raw = {ifc_mode, pll_lock, smp_err, sw_ext};

    spi_cfg_sync #(.WIDTH(STAT_IN_W), .STAGES(SYNC_STAGES)) u_stat_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (stat_raw),
        .dout  (stat_s)
    );

    always_comb begin
        status      = '0;
        status.rev  = PROTO_REV;
        status.ifc  = stat_s[4*CH_COUNT-1:3*CH_COUNT];
        status.lock = stat_s[3*CH_COUNT-1:2*CH_COUNT];
        status.smp  = stat_s[2*CH_COUNT-1:CH_COUNT];
        status.rf   = stat_s[CH_COUNT-1:0] | ctrl_q.rf;
    end

    spi_cfg_shifter #(.BITS(FRAME_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_s    (sel_s),
        .sclk_s   (sclk_s),
        .mosi_s   (mosi_s),
        .status_i (status),
        .miso_o   (cfg_miso),
        .commit_o (commit),
        .word_o   (word)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (commit) begin
            ctrl_d      = ctrl_t'(word);
            ctrl_d.rsvd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_rf
        assign rf_sw[c] = ctrl_q.rf[c] | sw_ext[c];
    end

    assign led       = ctrl_q.led;
    assign profile   = ctrl_q.profile;
    assign io_update = ctrl_q.io_upd;
    assign mask_nu   = ctrl_q.mask_nu;
    assign clk_sel   = {ctrl_q.clk_sel1, ctrl_q.clk_sel0};
    assign sync_sel  = ctrl_q.sync_sel;
    assign dds_rst   = ctrl_q.dds_rst;
    assign io_rst    = ctrl_q.io_rst;
    assign clk_div   = ctrl_q.clk_div;

    // R3: control outputs hold unless a capture pulse arrives
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ctrl_q));

    // R9: the update line takes bit 12 of the captured word
    a_r9_ioupd: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> io_update == $past(word[12]));

    // R2: the unused position is never kept
    a_r2_rsvd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.rsvd == 1'b0);
endmodule

// File: tb/spi_cfg_router_tb.sv
module spi_cfg_router_tb;
    localparam int H = 8; // SCLK half period in clk cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_cs = '0;
    logic       host_sclk = 1'b0, host_mosi = 1'b0, host_miso;
    logic       att_sel, fwd_sclk, fwd_mosi;
    logic [3:0] syn_sel;
    logic       att_miso = 1'b0;
    logic [3:0] syn_miso = '0, sw_ext = '0, smp_err = '0, pll_lock = '0, ifc_mode = '0;
    logic [3:0] rf_sw, led, mask_nu;
    logic [2:0] profile;
    logic       io_update, sync_sel, dds_rst, io_rst;
    logic [1:0] clk_sel, clk_div;

    int checks = 0, errors = 0;
    logic [23:0] exp_cfg = '0;
    logic [23:0] rd;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    spi_cfg_router u_dut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_sclk(host_sclk),
        .host_mosi(host_mosi), .host_miso(host_miso), .att_sel(att_sel),
        .syn_sel(syn_sel), .fwd_sclk(fwd_sclk), .fwd_mosi(fwd_mosi),
        .att_miso(att_miso), .syn_miso(syn_miso), .sw_ext(sw_ext),
        .smp_err(smp_err), .pll_lock(pll_lock), .ifc_mode(ifc_mode),
        .rf_sw(rf_sw), .led(led), .profile(profile), .io_update(io_update),
        .mask_nu(mask_nu), .clk_sel(clk_sel), .sync_sel(sync_sel),
        .dds_rst(dds_rst), .io_rst(io_rst), .clk_div(clk_div)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [23:0] exp_status(logic [23:0] cfg);
        return {1'b0, 7'h08, ifc_mode, pll_lock, smp_err, cfg[3:0] | sw_ext};
    endfunction

    // bit positions per R2, output pins collected in the same order
    function automatic logic [23:0] outs_word();
        logic [23:0] w = '0;
        w[3:0] = rf_sw; w[7:4] = led; w[10:8] = profile; w[12] = io_update;
        w[16:13] = mask_nu; w[17] = clk_sel[0]; w[18] = sync_sel;
        w[19] = dds_rst; w[20] = io_rst; w[21] = clk_sel[1]; w[23:22] = clk_div;
        return w;
    endfunction

    function automatic logic [23:0] exp_outs(logic [23:0] cfg);
        logic [23:0] w = cfg;
        w[11] = 1'b0;
        w[3:0] = cfg[3:0] | sw_ext;
        return w;
    endfunction

    task automatic xfer(logic [2:0] code, int nbits, logic [31:0] data, output logic [23:0] got);
        got = '0;
        host_cs = code;
        wait_clk(10);
        for (int i = 0; i < nbits; i++) begin
            host_mosi = data[nbits-1-i];
            wait_clk(H);
            got = {got[22:0], host_miso};
            host_sclk = 1'b1;
            wait_clk(H);
            host_sclk = 1'b0;
        end
        wait_clk(H);
        host_cs = '0;
        host_mosi = 1'b0;
        wait_clk(10);
    endtask

    task automatic route_check(logic [2:0] code);
        logic [3:0] want_syn;
        logic       want_att;
        want_att = (code == 3'd2);
        want_syn = (code == 3'd3) ? 4'hF : (code >= 3'd4) ? 4'(1 << (code - 3'd4)) : 4'h0;
        host_cs = code;
        for (int v = 0; v < 2; v++) begin
            att_miso = v[0]; syn_miso = v[0] ? 4'b0101 : 4'b1010;
            host_sclk = v[0]; host_mosi = ~v[0];
            wait_clk(1);
            if (code == 3'd2) check("R5 att return", host_miso, att_miso);
            if (code == 3'd3) check("R6 broadcast return", host_miso, syn_miso[0]);
            if (code >= 3'd4) check("R7 channel return", host_miso, syn_miso[code - 3'd4]);
            if (code <= 3'd1) begin
                check("R10 quiet fwd", {fwd_sclk, fwd_mosi}, 2'b00);
            end else begin
                check("R5 forward lines", {fwd_sclk, fwd_mosi}, {host_sclk, host_mosi});
            end
        end
        check(code == 3'd3 ? "R6 selects" : code >= 3'd4 ? "R7 selects" : code == 3'd2 ? "R5 selects" : "R10 selects",
              {att_sel, syn_sel}, {want_att, want_syn});
        host_cs = '0; host_sclk = 1'b0; host_mosi = 1'b0; att_miso = 1'b0; syn_miso = '0;
        wait_clk(10);
        check("R5 outputs untouched by routing", outs_word(), exp_outs(exp_cfg));
    endtask

    initial begin
        logic [23:0] w;
        void'($urandom(32'd24601));
        wait_clk(3);
        // R1 reset state
        check("R1 reset outputs", outs_word(), 24'h0);
        check("R1 reset selects", {att_sel, syn_sel, host_miso}, '0);
        rst_n = 1'b1;
        wait_clk(4);
        sw_ext = 4'b1001;
        wait_clk(1);
        check("R8 ext lines unclocked", rf_sw, 4'b1001);
        sw_ext = '0;

        // R2 / R4 directed: all ones, then alternating
        smp_err = 4'hA; pll_lock = 4'h5; ifc_mode = 4'hC;
        wait_clk(5);
        xfer(3'd1, 24, 32'hFFFFFF, rd);
        check("R4 status readback", rd, exp_status(exp_cfg));
        exp_cfg = 24'hFFFFFF;
        check("R2 all ones", outs_word(), exp_outs(exp_cfg));
        xfer(3'd1, 24, 32'h5A1234, rd);
        check("R4 status after write", rd, exp_status(exp_cfg));
        exp_cfg = 24'h5A1234;
        check("R2 pattern", outs_word(), exp_outs(exp_cfg));

        // R3 wrong lengths
        xfer(3'd1, 23, 32'h000000, rd);
        check("R3 short frame ignored", outs_word(), exp_outs(exp_cfg));
        xfer(3'd1, 25, 32'h0000000, rd);
        check("R3 long frame ignored", outs_word(), exp_outs(exp_cfg));

        // R9 pulse
        w = 24'h001000;
        xfer(3'd1, 24, {8'h0, w}, rd); exp_cfg = w;
        check("R9 update high", io_update, 1'b1);
        xfer(3'd1, 24, 32'h0, rd); exp_cfg = '0;
        check("R9 update low", io_update, 1'b0);

        // R8 OR with cfg bits
        xfer(3'd1, 24, 32'h000003, rd); exp_cfg = 24'h3;
        sw_ext = 4'b0100;
        wait_clk(1);
        check("R8 rf or", rf_sw, 4'b0111);
        sw_ext = '0;

        // routing for every code
        for (int c = 0; c < 8; c++) begin
            if (c != 1) route_check(3'(c));
        end

        // random frames
        for (int k = 0; k < 40; k++) begin
            logic [23:0] nw;
            nw = 24'($urandom());
            smp_err = 4'($urandom()); pll_lock = 4'($urandom());
            ifc_mode = 4'($urandom()); sw_ext = 4'($urandom());
            wait_clk(6);
            if (k % 5 == 4) begin
                xfer(3'd1, 24 + ((k % 2) ? 2 : -3), {8'h0, nw}, rd);
                check("R3 random bad length", outs_word(), exp_outs(exp_cfg));
            end else begin
                xfer(3'd1, 24, {8'h0, nw}, rd);
                check("R4 random status", rd, exp_status(exp_cfg));
                exp_cfg = nw;
                check("R2 random capture", outs_word(), exp_outs(exp_cfg));
            end
        end
        done = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done && n < 150000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule